// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers twelve interrupt sources into one prioritised request for a processor. Each source has a control byte that software writes. The byte holds an enable, a three-bit priority level, a pending flag and a few per-kind extras. A general register holds a master enable, and a base register sets where the vector range starts. The block presents the highest priority level among the active sources as a three-bit request.

When the processor runs an acknowledge cycle for a level, the block answers on the following cycle. It returns a vector equal to the base plus the index of the winning source. Sources come in three kinds:

- Level sources follow their input line.
- The abort-switch source latches a rising edge until software clears it.
- The two software sources are raised and cleared only by register writes.

For the serial source, one control bit chooses whether this block or the serial peripheral supplies the vector.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every source control byte reads 0x00, the general register reads 0x00, the vector base reads 0x40, the request level is 0 and no vector is valid.
- R2: The registered request level equals the largest priority among sources that are pending and enabled. A source with priority 0 never raises it.
- R3: While bit 4 of the general register (address 12) is 0, the request level is 0 and no acknowledge returns a valid vector.
- R4: A source whose enable bit (bit 3 of its control byte) is 0 contributes nothing to the request level or to arbitration.
- R5: An acknowledge for a level returns a valid vector one cycle later. The winner is the lowest-index active source at exactly that level.
- R6: The vector is the base plus the source index, in this index order: power-fail 0, bus error 1, abort 2, serial 3, ethernet 4, SCSI 5, DMA 6, printer 7, timer A 8, timer B 9, software A 10, software B 11. The control byte of source i sits at address i.
- R7: An acknowledge for level 0, or for a level with no active source, returns no valid vector.
- R8: The abort source (index 2) has these bits. Bit 6 reads the sampled switch input. Bit 7 sets on a rising edge of the switch and stays set after release. Writing 1 to bit 7 clears it.
- R9: A software source (index 10 or 11) has these bits. A write with bit 6 set raises its pending bit. A write with bit 7 set clears it. Its input line never changes the pending bit.
- R10: For the other sources, bit 7 reads the sampled input line, and writing bit 7 has no effect.
- R11: When the serial source wins an acknowledge, the vector-ownership output follows bit 4 of its control byte. For any other winner it is 1.
- R12: The vector base at address 13 is writable and reads back. Read data appears one cycle after the address. Addresses 14 and 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| src_in | input | 12 | Source request lines, bit i is source i |
| irq_level | output | 3 | Registered request level to the processor |
| iack | input | 1 | Acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector answer valid |
| vec_out | output | 8 | Vector number |
| vec_own | output | 1 | 1 when this block supplies the vector |

## Verification
On every cycle, the assertions check four things:
- A cleared master enable forces the request level to zero.
- No vector appears without an acknowledge or for level zero.
- A latched edge or software pending bit holds until a clearing write.
- A serial answer the peripheral owns always carries base plus three.

Only the directed scenarios can show the rest:
- which source wins a tie;
- the exact vector numbers;
- the abort switch's live and latched bits;
- software raising of interrupts;
- that writes to level sources and input edges on software sources change nothing.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC      = 12;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int IDX_ABORT = 2;
  localparam int IDX_SER   = 3;
  localparam int IDX_SWA   = 10;
  localparam int IDX_SWB   = 11;
  localparam int GEN_ADDR  = 12;
  localparam int BASE_ADDR = 13;
  localparam int B_PEND    = 7;
  localparam int B_RAISE   = 6;
  localparam int B_GEN_EN  = 4;

  typedef enum logic [1:0] {K_LEVEL, K_EDGE, K_SOFT} src_kind_e;

  function automatic src_kind_e kind_of(input int idx);
    if (idx == IDX_ABORT) return K_EDGE;
    if (idx == IDX_SWA || idx == IDX_SWB) return K_SOFT;
    return K_LEVEL;
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_vec_pkg::*;
#(
  parameter src_kind_e KIND = K_LEVEL,
  parameter int DW = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [DW-1:0]    wr_data,
  input  logic             src_in,
  output logic             pend,
  output logic             en,
  output logic [LVL_W-1:0] prio,
  output logic             own,
  output logic [DW-1:0]    rd_byte
);
  localparam int CTL_W = DW - 2;

  logic [CTL_W-1:0] ctl_q;
  logic src_q, pend_q;
  logic rise, raise_stb, clr_stb, set_ev, keep;

  assign rise      = src_in & ~src_q;
  assign raise_stb = sel_wr & wr_data[B_RAISE];
  assign clr_stb   = sel_wr & wr_data[B_PEND];
  assign set_ev    = (KIND == K_EDGE) ? rise :
                     (KIND == K_SOFT) ? raise_stb : src_in;
  assign keep      = (KIND == K_LEVEL) ? 1'b0 : ~clr_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      src_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_in;
      pend_q <= set_ev | (pend_q & keep);
      if (sel_wr) ctl_q <= wr_data[CTL_W-1:0];
    end
  end

  assign pend    = pend_q;
  assign en      = ctl_q[3];
  assign prio    = ctl_q[LVL_W-1:0];
  assign own     = ctl_q[4];
  assign rd_byte = {pend_q, src_q, ctl_q};

  // R8 / R9: a latched pending bit survives until a clearing write
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((KIND != K_LEVEL) && pend_q && !clr_stb) |=> pend_q);
  // R9: software pending never moves without a write to its byte
  p_soft_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((KIND == K_SOFT) && !sel_wr) |=> $stable(pend_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 12,
  parameter int LVL_W = 3,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             act,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]            qlvl,
  output logic [LVL_W-1:0]            max_lvl,
  output logic                        hit,
  output logic [IDX_W-1:0]            win
);
  always_comb begin
    max_lvl = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i] && lvl[i] > max_lvl) max_lvl = lvl[i];
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i] && lvl[i] == qlvl && qlvl != '0) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int DW = 8,
  parameter int LVL_W = 3,
  parameter int ADDR_W = 4,
  parameter logic [7:0] BASE_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NSRC-1:0]   src_in,
  output logic [LVL_W-1:0]  irq_level,
  input  logic              iack,
  input  logic [LVL_W-1:0]  iack_level,
  output logic              vec_valid,
  output logic [DW-1:0]     vec_out,
  output logic              vec_own
);
  logic [NSRC-1:0]            pend, en, own, act;
  logic [NSRC-1:0][LVL_W-1:0] prio;
  logic [NSRC-1:0][DW-1:0]    slot_rd;
  logic [DW-1:0]              gen_q, base_q, rd_next;
  logic                       glob_en, hit, own_next;
  logic [LVL_W-1:0]           max_lvl;
  logic [IDX_W-1:0]           win;

  assign glob_en = gen_q[B_GEN_EN];

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    irq_src_slot #(.KIND(kind_of(g)), .DW(DW), .LVL_W(LVL_W)) u_slot (
      .clk(clk), .rst(rst),
      .sel_wr(wr_en && addr == ADDR_W'(g)),
      .wr_data(wr_data), .src_in(src_in[g]),
      .pend(pend[g]), .en(en[g]), .prio(prio[g]), .own(own[g]),
      .rd_byte(slot_rd[g])
    );
    assign act[g] = pend[g] & en[g] & glob_en;
  end

  irq_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .act(act), .lvl(prio), .qlvl(iack_level),
    .max_lvl(max_lvl), .hit(hit), .win(win)
  );

  assign own_next = !(win == IDX_W'(IDX_SER) && !own[IDX_SER]);

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NSRC; i++)
      if (addr == ADDR_W'(i)) rd_next = slot_rd[i];
    if (addr == ADDR_W'(GEN_ADDR))  rd_next = gen_q;
    if (addr == ADDR_W'(BASE_ADDR)) rd_next = base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q     <= '0;
      base_q    <= BASE_RST;
      rd_data   <= '0;
      irq_level <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      vec_own   <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(GEN_ADDR))  gen_q  <= wr_data;
      if (wr_en && addr == ADDR_W'(BASE_ADDR)) base_q <= wr_data;
      rd_data   <= rd_next;
      irq_level <= max_lvl;
      vec_valid <= iack && hit;
      vec_out   <= base_q + DW'(win);
      vec_own   <= own_next;
    end
  end

  // R3: master enable off silences the request on the next cycle
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (irq_level == '0));
  // R5: no vector answer without an acknowledge
  p_ack_only_r5: assert property (@(posedge clk) disable iff (rst)
    !iack |=> !vec_valid);
  // R7: level 0 is never answered
  p_lvl0_none_r7: assert property (@(posedge clk) disable iff (rst)
    (iack && iack_level == '0) |=> !vec_valid);
  // R11: a peripheral-owned answer can only be the serial vector
  p_ser_vec_r11: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_own) |-> (vec_out == DW'($past(base_q) + DW'(IDX_SER))));
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, iack = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] src_in = '0;
  logic [2:0] iack_level = '0;
  logic [7:0] rd_data, vec_out;
  logic [2:0] irq_level;
  logic vec_valid, vec_own;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_in(src_in), .irq_level(irq_level), .iack(iack),
    .iack_level(iack_level), .vec_valid(vec_valid), .vec_out(vec_out),
    .vec_own(vec_own)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    src_in = '0; iack = 1'b0; wr_en = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic lvl(input logic [2:0] exp, input string req);
    repeat (2) @(negedge clk);
    chk(req, {5'd0, irq_level}, {5'd0, exp});
  endtask

  task automatic ack(input logic [2:0] l, input logic v, input logic [7:0] vec,
                     input logic own, input string req);
    iack = 1'b1; iack_level = l;
    @(negedge clk);
    chk(req, {7'd0, vec_valid}, {7'd0, v});
    if (v) begin
      chk(req, vec_out, vec);
      chk(req, {7'd0, vec_own}, {7'd0, own});
    end
    iack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 level", {5'd0, irq_level}, 8'h00);
    chk("R1 valid", {7'd0, vec_valid}, 8'h00);
    rd(4'd5, 8'h00, "R1 ctrl");
    rd(4'd12, 8'h00, "R1 general");
    rd(4'd13, 8'h40, "R1 base");
    rd(4'd14, 8'h00, "R12 unused addr");
  endtask

  task automatic t_levels();
    do_reset();
    wr(4'd12, 8'h10);
    wr(4'd4, 8'h0B);
    src_in[4] = 1'b1;
    lvl(3'd3, "R2 single");
    src_in[6] = 1'b1;
    wr(4'd6, 8'h0D);
    lvl(3'd5, "R2 max");
    wr(4'd6, 8'h05);
    lvl(3'd3, "R4 disabled");
    wr(4'd5, 8'h08);
    src_in[5] = 1'b1;
    lvl(3'd3, "R2 prio0");
    wr(4'd12, 8'h00);
    lvl(3'd0, "R3 global off");
    ack(3'd3, 1'b0, 8'h00, 1'b0, "R3 ack off");
    wr(4'd12, 8'h10);
    lvl(3'd3, "R3 global on");
  endtask

  task automatic t_vectors();
    do_reset();
    wr(4'd12, 8'h10);
    wr(4'd4, 8'h0B);
    wr(4'd7, 8'h0B);
    src_in[4] = 1'b1; src_in[7] = 1'b1;
    lvl(3'd3, "R2 tie");
    ack(3'd3, 1'b1, 8'h44, 1'b1, "R5 tie lowest");
    src_in[4] = 1'b0;
    lvl(3'd3, "R2 printer");
    ack(3'd3, 1'b1, 8'h47, 1'b1, "R6 printer");
    ack(3'd6, 1'b0, 8'h00, 1'b0, "R7 empty level");
    ack(3'd0, 1'b0, 8'h00, 1'b0, "R7 level0");
    wr(4'd13, 8'h80);
    rd(4'd13, 8'h80, "R12 base rd");
    ack(3'd3, 1'b1, 8'h87, 1'b1, "R12 new base");
  endtask

  task automatic t_abort();
    do_reset();
    wr(4'd12, 8'h10);
    wr(4'd2, 8'h0E);
    src_in[2] = 1'b1;
    @(negedge clk);
    rd(4'd2, 8'hCE, "R8 pressed");
    lvl(3'd6, "R8 level");
    src_in[2] = 1'b0;
    @(negedge clk);
    rd(4'd2, 8'h8E, "R8 latched");
    lvl(3'd6, "R8 held");
    ack(3'd6, 1'b1, 8'h42, 1'b1, "R6 abort");
    wr(4'd2, 8'h8E);
    rd(4'd2, 8'h0E, "R8 cleared");
    lvl(3'd0, "R8 level gone");
  endtask

  task automatic t_soft();
    do_reset();
    wr(4'd12, 8'h10);
    wr(4'd10, 8'h4F);
    rd(4'd10, 8'h8F, "R9 raised");
    lvl(3'd7, "R9 level");
    ack(3'd7, 1'b1, 8'h4A, 1'b1, "R6 soft A");
    src_in[10] = 1'b1;
    @(negedge clk);
    rd(4'd10, 8'hCF, "R9 input ignored");
    wr(4'd10, 8'h8F);
    rd(4'd10, 8'h4F, "R9 cleared");
    lvl(3'd0, "R9 level gone");
    src_in[10] = 1'b0;
    src_in[11] = 1'b1;
    @(negedge clk);
    lvl(3'd0, "R9 input no raise");
  endtask

  task automatic t_levelsrc();
    do_reset();
    wr(4'd1, 8'h09);
    src_in[1] = 1'b1;
    @(negedge clk);
    rd(4'd1, 8'hC9, "R10 follows");
    wr(4'd1, 8'h89);
    rd(4'd1, 8'hC9, "R10 write ignored");
    src_in[1] = 1'b0;
    @(negedge clk);
    rd(4'd1, 8'h09, "R10 drops");
  endtask

  task automatic t_serial();
    do_reset();
    wr(4'd12, 8'h10);
    wr(4'd3, 8'h1A);
    src_in[3] = 1'b1;
    lvl(3'd2, "R11 level");
    ack(3'd2, 1'b1, 8'h43, 1'b1, "R11 own set");
    wr(4'd3, 8'h0A);
    ack(3'd2, 1'b1, 8'h43, 1'b0, "R11 own clear");
  endtask

  initial begin
    #(4 * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_levels();
    t_vectors();
    t_abort();
    t_soft();
    t_levelsrc();
    t_serial();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule